// File: doc/BRIEF.md
# Three-Wire Serial Memory Device Model

This block is a synthesizable device-side model of a small serial memory. The default array holds 64 words of 16 bits. A host selects the device with a chip-select line. It shifts commands in on a data line, timed by a serial clock, and receives read data or ready/busy status on a data output that can be released. All three host lines are brought into the system clock domain through two-flop synchronizers. The state machine acts on the rising edges of the synchronized serial clock.

A command is a start bit, a two-bit opcode and an address field. Programming commands (word write, word erase, fill with ones, fill with a data word) are accepted only while a write-permit latch is set. After programming, the model stays busy for a fixed number of system clocks. A host that deselects and then reselects the device during that period sees the busy state and then the ready state on the data output.

State machine states: `ST_IDLE` (deselected), `ST_START` (selected, waiting for the start bit), `ST_CMD` (shifting in the opcode and address), `ST_RDATA` (driving read data), `ST_WDATA` (shifting in a data word), `ST_STATUS` (showing ready/busy), `ST_DONE` (command finished, output released).

State machine transitions:
- `ST_IDLE` goes to `ST_STATUS` when chip select rises during busy, and to `ST_START` when it rises otherwise.
- `ST_START` goes to `ST_CMD` on a 1 bit.
- `ST_CMD` goes to `ST_RDATA`, `ST_WDATA` or `ST_DONE` when the last address bit arrives.
- `ST_WDATA` goes to `ST_DONE` on the last data bit.
- `ST_RDATA` goes to `ST_DONE` on the clock edge after the last data bit.
- Any state goes to `ST_IDLE` when chip select falls.

Top module: `sermem_dev`

## Requirements
- R1: A command is a start bit of 1 followed by a 2-bit opcode and an ADDR_W-bit address. All are sent MSB first and sampled on serial clock rising edges. Zeros received before the start bit are ignored.
- R2: Opcode 10 is a read. After the last address bit the output drives a 0 dummy bit. Each following serial clock rise then presents the next data bit, MSB first. The rise after the last data bit releases the output.
- R3: After reset, programming is not permitted, every word reads as all ones, and the output enable is low.
- R4: Opcode 01 is a word write. It is followed by DATA_W data bits, MSB first, and stores them at the address with no prior erase needed.
- R5: Opcode 11 sets every bit of the addressed word to 1.
- R6: With opcode 00, the two most significant address bits select the action: 11 permits programming and 00 forbids it. The remaining address bits are ignored.
- R7: With opcode 00, top address bits 10 fill every word with ones. Top address bits 01 take DATA_W data bits and write them into every word.
- R8: While programming is forbidden, the write, erase and both fill commands leave the array unchanged. Reads work in either state.
- R9: Each programming command starts a busy period of BUSY_CYCLES system clocks. For the write and data-fill commands it starts after the last data bit. For the erase and ones-fill commands it starts after the last address bit.
- R10: If chip select is raised while busy, the output is enabled and shows 0 while busy. It shows 1 once ready and holds 1 until chip select falls.
- R11: If chip select is raised after the busy period has ended, no status is shown.
- R12: Serial input received while the status is shown is ignored.
- R13: The output enable is low whenever chip select is low, after the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| sdi_i | input | 1 | Serial command and data input |
| sdo_o | output | 1 | Serial data or ready/busy output |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
The bench builds the model with a 4-bit address, 8-bit words and a 40-clock busy period. With only 16 words, every address can be written, read, erased and filled in each phase of the test, against a model array computed in the bench. With the short busy period, the status sequence can be observed in full: busy, then the change to ready, then its absence after a late reselect. The 4-bit address also leaves two don't-care bits under the opcode-00 selector, and the bench sends different values in them.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_CMD,
        ST_RDATA,
        ST_WDATA,
        ST_STATUS,
        ST_DONE
    } sm_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_PERMIT = 2'b11;
    localparam logic [1:0] SUB_ONES   = 2'b10;
    localparam logic [1:0] SUB_FILL   = 2'b01;
    localparam logic [1:0] SUB_LOCK   = 2'b00;

endpackage

// File: rtl/sermem_sync.sv
module sermem_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o,
    output logic [N-1:0] rise_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [2:0] sh;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[1:0], async_i[g]};
        end
        assign sync_o[g] = sh[1];
        assign rise_o[g] = sh[1] & ~sh[2];
    end

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              all_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '1;
        end else if (we_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (all_i || addr_i == ADDR_W'(i)) words[i] <= wdata_i;
            end
        end
    end

    assign rdata_o = words[addr_i];

endmodule

// File: rtl/sermem_busy.sv
module sermem_busy #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start_i)    cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);

endmodule

// File: rtl/sermem_dev.sv
module sermem_dev
    import sermem_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int BUSY_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o,
    output logic sdo_oe_o
);

    localparam int CMD_W = 2 + ADDR_W;
    localparam int MAX_W = (DATA_W > CMD_W) ? DATA_W : CMD_W;
    localparam int CNT_W = $clog2(MAX_W + 1);

    logic [2:0] sync_q, rise_q;
    logic       cs_s, cs_rise, sk_rise, di_s;

    sermem_sync #(.N(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdi_i, sclk_i, cs_i}),
        .sync_o  (sync_q),
        .rise_o  (rise_q)
    );

    assign cs_s    = sync_q[0];
    assign cs_rise = rise_q[0];
    assign sk_rise = rise_q[1];
    assign di_s    = sync_q[2];

    sm_state_e          st, st_n;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CMD_W-1:0]   cmd_sr;
    logic [DATA_W-1:0]  data_sr;
    logic [ADDR_W-1:0]  addr_q;
    logic               wr_all_q, rd_bit, wen;
    logic               busy;

    logic [CMD_W-1:0]   cmd_word;
    logic [DATA_W-1:0]  data_word;
    logic [1:0]         opc, sub;
    logic               last_cmd, last_data;
    logic               mem_we, mem_all, busy_go, en_set, en_clr;
    logic [ADDR_W-1:0]  mem_addr;
    logic [DATA_W-1:0]  mem_wdata, mem_rdata;

    assign cmd_word  = {cmd_sr[CMD_W-2:0], di_s};
    assign data_word = {data_sr[DATA_W-2:0], di_s};
    assign opc       = cmd_word[CMD_W-1 -: 2];
    assign sub       = cmd_word[ADDR_W-1 -: 2];
    assign last_cmd  = (st == ST_CMD)   && sk_rise && (bit_cnt == CNT_W'(CMD_W - 1));
    assign last_data = (st == ST_WDATA) && sk_rise && (bit_cnt == CNT_W'(DATA_W - 1));
    assign mem_addr  = (st == ST_WDATA) ? addr_q : cmd_word[ADDR_W-1:0];

    // next state and command strobes
    always_comb begin
        st_n      = st;
        mem_we    = 1'b0;
        mem_all   = 1'b0;
        mem_wdata = '1;
        busy_go   = 1'b0;
        en_set    = 1'b0;
        en_clr    = 1'b0;
        unique case (st)
            ST_IDLE:   if (cs_rise) st_n = busy ? ST_STATUS : ST_START;
            ST_START:  if (sk_rise && di_s) st_n = ST_CMD;
            ST_CMD: begin
                if (last_cmd) begin
                    st_n = ST_DONE;
                    unique case (opc)
                        OPC_READ:  st_n = ST_RDATA;
                        OPC_WRITE: if (wen) st_n = ST_WDATA;
                        OPC_ERASE: begin
                            mem_we  = wen;
                            busy_go = wen;
                        end
                        default: begin
                            unique case (sub)
                                SUB_PERMIT: en_set = 1'b1;
                                SUB_LOCK:   en_clr = 1'b1;
                                SUB_ONES: begin
                                    mem_we  = wen;
                                    mem_all = 1'b1;
                                    busy_go = wen;
                                end
                                default:    if (wen) st_n = ST_WDATA;
                            endcase
                        end
                    endcase
                end
            end
            ST_WDATA: begin
                if (last_data) begin
                    mem_we    = 1'b1;
                    mem_all   = wr_all_q;
                    mem_wdata = data_word;
                    busy_go   = 1'b1;
                    st_n      = ST_DONE;
                end
            end
            ST_RDATA:  if (sk_rise && bit_cnt == CNT_W'(DATA_W)) st_n = ST_DONE;
            ST_STATUS: st_n = ST_STATUS;
            ST_DONE:   st_n = ST_DONE;
            default:   st_n = ST_IDLE;
        endcase
        if (!cs_s) st_n = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // shift registers, counters and the write-permit latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            cmd_sr   <= '0;
            data_sr  <= '0;
            addr_q   <= '0;
            wr_all_q <= 1'b0;
            rd_bit   <= 1'b0;
            wen      <= 1'b0;
        end else begin
            if (en_set)      wen <= 1'b1;
            else if (en_clr) wen <= 1'b0;
            if (sk_rise) begin
                unique case (st)
                    ST_START: bit_cnt <= '0;
                    ST_CMD: begin
                        cmd_sr  <= cmd_word;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (last_cmd) begin
                            bit_cnt  <= '0;
                            addr_q   <= cmd_word[ADDR_W-1:0];
                            wr_all_q <= (opc == 2'b00);
                            data_sr  <= mem_rdata;
                            rd_bit   <= 1'b0;
                        end
                    end
                    ST_WDATA: begin
                        data_sr <= data_word;
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    ST_RDATA: begin
                        if (bit_cnt != CNT_W'(DATA_W)) begin
                            rd_bit  <= data_sr[DATA_W-1];
                            data_sr <= {data_sr[DATA_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sdo_oe_o = 1'b0;
        sdo_o    = 1'b0;
        unique case (st)
            ST_RDATA: begin
                sdo_oe_o = 1'b1;
                sdo_o    = rd_bit;
            end
            ST_STATUS: begin
                sdo_oe_o = 1'b1;
                sdo_o    = ~busy;
            end
            default: ;
        endcase
    end

    sermem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .all_i   (mem_all),
        .addr_i  (mem_addr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

    sermem_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (busy_go),
        .busy_o  (busy)
    );

endmodule

// File: rtl/sermem_chk.sv
module sermem_chk
    import sermem_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cs_s,
    input logic      sk_rise,
    input sm_state_e st,
    input logic      mem_we,
    input logic      wen,
    input logic      busy,
    input logic      sdo_o,
    input logic      sdo_oe_o
);

    AST_DESELECT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && $past(!cs_s)) |-> !sdo_oe_o); // R13

    AST_PROG_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen); // R8

    AST_NO_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !busy); // R12

    AST_BUSY_AFTER_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> busy); // R9

    AST_READY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STATUS && sdo_o) |=> (st != ST_STATUS || sdo_o)); // R10

    AST_READ_ON_SK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDATA && $past(st) == ST_RDATA && !$past(sk_rise)) |-> $stable(sdo_o)); // R2

endmodule

bind sermem_dev sermem_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sk_rise  (sk_rise),
    .st       (st),
    .mem_we   (mem_we),
    .wen      (wen),
    .busy     (busy),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o)
);

// File: tb/sermem_dev_tb.sv
module sermem_dev_tb;

    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int BC    = 40;
    localparam int H     = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe;

    always #5 clk = ~clk;

    sermem_dev #(.ADDR_W(AW), .DATA_W(DW), .BUSY_CYCLES(BC)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs),
        .sclk_i   (sclk),
        .sdi_i    (sdi),
        .sdo_o    (sdo),
        .sdo_oe_o (sdo_oe)
    );

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];
    bit permit = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic skbit(input logic b);
        sclk = 1'b0; sdi = b; wclk(H);
        sclk = 1'b1;          wclk(H);
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) skbit(v[i]);
    endtask

    task automatic sel();
        sclk = 1'b0; cs = 1'b1; wclk(H);
    endtask

    task automatic desel();
        sclk = 1'b0; cs = 1'b0; wclk(H);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [AW-1:0] a);
        send({1'b1, op, a}, 3 + AW);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input int lead, input string req);
        logic [DW-1:0] got;
        bit oe_ok;
        got = '0;
        oe_ok = 1'b1;
        sel();
        if (lead > 0) send(0, lead);
        cmd(2'b10, a);
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R2 dummy bit", {sdo_oe, sdo}, 2'b10);
        for (int i = 0; i < DW; i++) begin
            skbit(1'b0);
            got = {got[DW-2:0], sdo};
            if (sdo_oe !== 1'b1) oe_ok = 1'b0;
        end
        chk(oe_ok && got === model[a], req, got, model[a]);
        skbit(1'b0);
        chk(sdo_oe === 1'b0, "R2 release after last bit", sdo_oe, 0);
        desel();
    endtask

    task automatic rd_all(input string req);
        for (int a = 0; a < DEPTH; a++) rd_check(AW'(a), 0, req);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel(); cmd(2'b01, a); send(d, DW); desel();
        if (permit) model[a] = d;
        wclk(BC + 10);
    endtask

    task automatic erase(input logic [AW-1:0] a);
        sel(); cmd(2'b11, a); desel();
        if (permit) model[a] = '1;
        wclk(BC + 10);
    endtask

    task automatic ext(input logic [1:0] s, input logic [1:0] low, input logic [DW-1:0] d);
        sel(); cmd(2'b00, {s, low});
        if (s == 2'b01) send(d, DW);
        desel();
        case (s)
            2'b11: permit = 1'b1;
            2'b00: permit = 1'b0;
            2'b10: if (permit) for (int i = 0; i < DEPTH; i++) model[i] = '1;
            default: if (permit) for (int i = 0; i < DEPTH; i++) model[i] = d;
        endcase
        wclk(BC + 10);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 29 + 7);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        wclk(5);
        rst_n = 1'b1;
        wclk(5);

        // R3: reset state
        chk(sdo_oe === 1'b0, "R3 output enable after reset", sdo_oe, 0);
        rd_all("R3 erased contents after reset");

        // R8: programming forbidden after reset
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), pat(a));
        ext(2'b01, 2'b10, 8'h3C);
        rd_all("R8 writes ignored while forbidden");

        // R6 permit, R4 write sweep, R1 framing
        ext(2'b11, 2'b01, '0);
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), pat(a));
        rd_all("R4 written word");
        rd_check(AW'(7), 3, "R1 leading zeros before start bit");

        // R4: overwrite without erase
        wr(AW'(9), ~pat(9));
        rd_check(AW'(9), 0, "R4 overwrite without erase");

        // R5: erase even words
        for (int a = 0; a < DEPTH; a += 2) erase(AW'(a));
        rd_all("R5 erase word");

        // R7: data fill and ones fill
        ext(2'b01, 2'b11, 8'hA5);
        rd_all("R7 data fill");
        ext(2'b10, 2'b00, '0);
        rd_all("R7 ones fill");

        // R9 R10 R12: status while busy
        sel(); cmd(2'b01, AW'(5)); send(8'h3C, DW); desel();
        model[5] = 8'h3C;
        sel();
        chk(sdo_oe === 1'b1 && sdo === 1'b0, "R10 busy status", {sdo_oe, sdo}, 2'b10);
        n = 0;
        while (sdo !== 1'b1 && n < 200) begin
            wclk(1);
            n++;
        end
        chk(n >= BC - 30 && n <= BC - 10, "R9 busy period length", n, BC - 20);
        cmd(2'b11, AW'(5));
        chk(sdo_oe === 1'b1 && sdo === 1'b1, "R10 ready held", {sdo_oe, sdo}, 2'b11);
        desel();
        chk(sdo_oe === 1'b0, "R13 release on deselect", sdo_oe, 0);
        wclk(BC + 10);
        rd_check(AW'(5), 0, "R12 command during status ignored");

        // R11: reselect after busy ended
        sel(); cmd(2'b11, AW'(6)); desel();
        model[6] = '1;
        wclk(BC + 10);
        sel();
        chk(sdo_oe === 1'b0, "R11 no status after busy", sdo_oe, 0);
        desel();

        // R13: deselect in the middle of a read
        sel(); cmd(2'b10, AW'(3)); skbit(1'b0); skbit(1'b0);
        chk(sdo_oe === 1'b1, "R13 driving mid read", sdo_oe, 1);
        desel();
        chk(sdo_oe === 1'b0, "R13 released mid read", sdo_oe, 0);

        // R6 forbid with different don't-care bits, R8 read still works
        ext(2'b00, 2'b11, '0);
        wr(AW'(2), 8'h00);
        erase(AW'(5));
        ext(2'b10, 2'b01, '0);
        rd_all("R8 forbidden after lock");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule